// File: doc/BRIEF.md
# Push-Pull Phase Splitter with Programmable Overlap or Dead Time

This block turns the period-start pulse of a buck converter's oscillator into two alternating drive phases for a push-pull stage. Every pulse hands conduction from one phase to the other. Each phase output therefore runs at half the buck switching frequency with a nominal 50% duty cycle.

At every handover the block can hold both phases in a common state for a programmed number of system-clock cycles. In overlap mode both phases are on, which keeps a path open for the inductor current of a current-fed stage. In dead-time mode both phases are off, which keeps a voltage-fed transformer from shorting its own drive.

The programmed count is limited to less than half of the most recently measured oscillator period, so that neither phase can disappear. Switching runs only while both the enable input and the reference-good input are high. It does not depend on any fault in the buck stage.

Top module: `pp_phase_split`

## Requirements
- R1: After reset, and while running but before the first period pulse arrives, both outputs are low.
- R2: The first period pulse after running starts (out of reset or after a stop) turns on phase A alone (out_a=1, out_b=0) in the following cycle, with no common window.
- R3: Each later period pulse hands conduction to the other phase, so each output completes one high/low cycle per two pulse intervals.
- R4: With overlap_mode=1 sampled at a pulse, both outputs are high for exactly E cycles after that pulse, then only the incoming phase is high.
- R5: With overlap_mode=0 sampled at a pulse, both outputs are low for exactly E cycles after that pulse, then only the incoming phase is high.
- R6: E = min(gap_cycles, L/2 - 1) with integer division, where L is the number of clock cycles between the two most recent pulses; E is 0 when L is below 4.
- R7: With E = 0, the phases swap in the cycle after the pulse and the outputs are never equal while running after the first pulse.
- R8: When enable or ref_ok is low, both outputs are low in the same cycle, and the next run starts again per R2.
- R9: overlap_mode is sampled only at a pulse; changing it during a window does not alter that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Switching enable |
| ref_ok | input | 1 | Reference supply good |
| period_tick | input | 1 | One-cycle oscillator period-start pulse |
| overlap_mode | input | 1 | 1 = overlap at handover, 0 = dead time |
| gap_cycles | input | GAP_W | Requested overlap or dead time in clock cycles |
| out_a | output | 1 | Phase A drive |
| out_b | output | 1 | Phase B drive |

## Verification
Directed handovers at a fixed ten-cycle period separate overlap windows from dead-time windows and check the exact window length. Short periods combined with large requests show whether the clamp follows the measured period rather than the request. A zero request with a run of pulses tells a clean swap apart from any spurious common state, and it also shows the divide-by-two frequency. Random periods, requests and modes, mixed with stops on either run input, show whether restart always begins on phase A and whether a mode flip inside a window is ignored.

// File: rtl/pp_phase_split.sv
module pp_phase_split #(
  parameter int GAP_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ref_ok,
  input  logic             period_tick,
  input  logic             overlap_mode,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             out_a,
  output logic             out_b
);
  localparam int CMP_W = (GAP_W > CNT_W) ? GAP_W : CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             run;
  logic             started_q;
  logic             phase_q;
  logic             a_q, b_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GAP_W-1:0] dcnt_q;
  logic [CMP_W-1:0] lim_x, gap_x, eff_x;
  logic [GAP_W-1:0] eff;
  logic             nph;

  assign run   = enable & ref_ok;
  assign nph   = ~phase_q;
  assign gap_x = CMP_W'(gap_cycles);
  assign lim_x = (cnt_q < CNT_W'(4)) ? '0 : CMP_W'((cnt_q >> 1) - CNT_W'(1));
  assign eff_x = (gap_x > lim_x) ? lim_x : gap_x;
  assign eff   = eff_x[GAP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      started_q <= 1'b0;
      phase_q   <= 1'b0;
      a_q       <= 1'b0;
      b_q       <= 1'b0;
      cnt_q     <= '0;
      dcnt_q    <= '0;
    end else if (period_tick) begin
      cnt_q <= CNT_W'(1);
      if (!started_q) begin
        started_q <= 1'b1;
        phase_q   <= 1'b0;
        a_q       <= 1'b1;
        b_q       <= 1'b0;
        dcnt_q    <= '0;
      end else begin
        phase_q <= nph;
        dcnt_q  <= eff;
        if (eff == '0) begin
          a_q <= ~nph;
          b_q <= nph;
        end else begin
          a_q <= overlap_mode;
          b_q <= overlap_mode;
        end
      end
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      if (dcnt_q != '0) begin
        dcnt_q <= dcnt_q - GAP_W'(1);
        if (dcnt_q == GAP_W'(1)) begin
          a_q <= ~phase_q;
          b_q <= phase_q;
        end
      end
    end
  end

  assign out_a = a_q & run;
  assign out_b = b_q & run;
endmodule

module pp_phase_split_chk #(
  parameter int GAP_W = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             ref_ok,
  input logic             period_tick,
  input logic [GAP_W-1:0] gap_cycles,
  input logic             out_a,
  input logic             out_b,
  input logic             started,
  input logic [CNT_W-1:0] cnt,
  input logic [GAP_W-1:0] dcnt
);
  logic run;
  assign run = enable & ref_ok;

  assert_first_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period_tick && !started) |=> (!(enable && ref_ok) || (out_a && !out_b)));

  assert_one_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started && dcnt == '0 && !period_tick) |=> (!(enable && ref_ok) || (out_a != out_b)));

  assert_window_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started && period_tick) |=>
      (dcnt <= $past(gap_cycles)) && ((32'(dcnt) << 1) < 32'($past(cnt)) || dcnt == '0));

  assert_clean_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started && period_tick && gap_cycles == '0 && dcnt == '0) |=>
      (!(enable && ref_ok) || (out_a == $past(out_b) && out_b == $past(out_a))));

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !started);
endmodule

bind pp_phase_split pp_phase_split_chk #(.GAP_W(GAP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ref_ok(ref_ok),
  .period_tick(period_tick), .gap_cycles(gap_cycles),
  .out_a(out_a), .out_b(out_b), .started(started_q), .cnt(cnt_q), .dcnt(dcnt_q)
);

// File: tb/tb_pp_phase_split.sv
module tb_pp_phase_split;
  localparam int GAP_W = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             ref_ok = 1'b0;
  logic             period_tick = 1'b0;
  logic             overlap_mode = 1'b0;
  logic [GAP_W-1:0] gap_cycles = '0;
  logic             out_a, out_b;

  int  total = 0;
  int  bad = 0;
  int  prev_L = 0;
  int  rises_a = 0;
  bit  first = 1'b1;
  bit  ph = 1'b0;
  bit  prev_a = 1'b0;

  pp_phase_split #(.GAP_W(GAP_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ref_ok(ref_ok),
    .period_tick(period_tick), .overlap_mode(overlap_mode),
    .gap_cycles(gap_cycles), .out_a(out_a), .out_b(out_b)
  );

  always #4 clk = ~clk;

  function automatic int eff_of(int g, int L);
    int lim;
    lim = (L < 4) ? 0 : (L / 2 - 1);
    return (g < lim) ? g : lim;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // called at posedge+2; returns at posedge+2 after loops cycles
  task automatic handover(int loops, bit flip);
    logic [1:0] winv, aft, exp;
    int e;
    string tag;
    if (first) begin
      e = 0; ph = 1'b0; tag = "R2"; first = 1'b0;
    end else begin
      ph = ~ph;
      e = eff_of(int'(gap_cycles), prev_L);
      if (gap_cycles == 0) tag = "R7";
      else if (e < int'(gap_cycles)) tag = "R6";
      else tag = overlap_mode ? "R4" : "R5";
    end
    winv = overlap_mode ? 2'b11 : 2'b00;
    aft  = ph ? 2'b01 : 2'b10;
    period_tick = 1'b1;
    @(posedge clk); #2 period_tick = 1'b0;
    for (int j = 0; j < loops; j++) begin
      @(negedge clk);
      exp = (j < e) ? winv : aft;
      chk((flip && j > 0 && j < e) ? "R9" : tag, {out_a, out_b}, exp);
      if (out_a && !prev_a) rises_a++;
      prev_a = out_a;
      @(posedge clk); #2;
      if (flip && j == 0) overlap_mode = ~overlap_mode;
    end
    prev_L = loops + 1;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {out_a, out_b}, 2'b00);
    @(posedge clk); #2;
    rst_n = 1'b1; enable = 1'b1; ref_ok = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R1", {out_a, out_b}, 2'b00);
      @(posedge clk); #2;
    end

    // overlap then dead time at period 10
    overlap_mode = 1'b1; gap_cycles = 3;
    handover(9, 0);
    handover(9, 0);
    handover(9, 0);
    overlap_mode = 1'b0; gap_cycles = 2;
    handover(9, 0);
    handover(9, 0);

    // clamp against measured period
    overlap_mode = 1'b1; gap_cycles = 50;
    handover(4, 0);
    handover(4, 0);
    handover(2, 0);
    overlap_mode = 1'b0;
    handover(9, 0);
    handover(9, 0);

    // mode flip inside a window
    gap_cycles = 4; overlap_mode = 1'b1;
    handover(9, 1);
    handover(9, 1);

    // stop on enable, restart with phase A
    enable = 1'b0;
    @(negedge clk);
    chk("R8", {out_a, out_b}, 2'b00);
    @(posedge clk); #2 period_tick = 1'b1;
    @(posedge clk); #2 period_tick = 1'b0;
    @(negedge clk);
    chk("R8", {out_a, out_b}, 2'b00);
    @(posedge clk); #2 enable = 1'b1;
    first = 1'b1;
    handover(9, 0);
    handover(9, 0);

    // stop on ref_ok
    ref_ok = 1'b0;
    @(negedge clk);
    chk("R8", {out_a, out_b}, 2'b00);
    @(posedge clk); #2 ref_ok = 1'b1;
    first = 1'b1;
    gap_cycles = 0;
    rises_a = 0; prev_a = 1'b0;
    handover(7, 0);
    for (int k = 0; k < 8; k++) handover(7, 0);
    chk_int("R3", rises_a, 5);

    // random
    for (int n = 0; n < 300; n++) begin
      gap_cycles   = GAP_W'($urandom_range(0, 12));
      overlap_mode = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 14) == 0) begin
        if ($urandom_range(0, 1) == 1) enable = 1'b0; else ref_ok = 1'b0;
        repeat ($urandom_range(1, 4)) begin
          @(negedge clk);
          chk("R8", {out_a, out_b}, 2'b00);
          @(posedge clk); #2;
        end
        enable = 1'b1; ref_ok = 1'b1;
        first = 1'b1;
      end
      handover($urandom_range(1, 20), 1'($urandom_range(0, 3) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule